// File: doc/BRIEF.md
# Switch Reset and Port Bring-Up Sequencer

This block takes a multi-port Ethernet switch from an unknown state to a simple forwarding setup built around one CPU-facing port. After a single start pulse it works only through a generic register-access request port. That port carries a device address, a register address, write data and a read/write flag. It returns a done strobe, read data and an error flag. The bus protocol behind that port is handled elsewhere.

The run has these steps. First every port is shut off. The block then waits a fixed time so the queues can drain. Next it sets the switch-wide soft reset bit and polls it until the bit clears, with a bound on the number of polls. After that it points the switch's CPU destination field at the CPU port. It opens the CPU port towards every other port. Last, it brings up each PHY port selected by a mask, and each of those ports can reach only the CPU.

Every register change is a read-modify-write. Only the targeted field is replaced, so the other bits of each register keep their values.

Top module: `switch_bringup_seq`

## Requirements
- R1: A start pulse is accepted only while `busy` is low. `busy` is high from the cycle after an accepted start until the run ends. A start while busy has no effect on the access sequence.
- R2: A request raises `reqValid` and holds it, with `reqWrite`, `reqDev`, `reqReg` and `reqWdata` unchanged, until the cycle where `rspDone` is high. The next request is presented at the earliest in the following cycle.
- R3: For every port p, in ascending order from 0 to NUM_PORTS-1, the block reads device 0x10+p register 0x04. It then writes that register back with bits 1:0 (port state) set to 0 and all other bits as read.
- R4: After the last disable write completes, no request is issued for at least DRAIN_MS x CYC_PER_MS cycles.
- R5: The block then reads device 0x1B register 0x04 and writes it back with bit 15 set and all other bits as read.
- R6: The block reads device 0x1B register 0x04 until bit 15 reads 0. Consecutive polls are at least CYC_PER_MS cycles apart. If MAX_POLLS reads all return bit 15 set, the run ends with no further requests, and `timedOut` stays high until the next accepted start.
- R7: When the reset clears, the block reads device 0x1B register 0x1A and writes bits 7:4 with CPU_PORT, keeping all other bits.
- R8: The CPU port is configured next, one read-modify-write per step, in this order. Register 0x07 bits 11:0 get CPU_PORT+1. Register 0x06 bits 10:0 get a mask of all ports except CPU_PORT. Register 0x04 bits 1:0 get 3 (forwarding).
- R9: Next, each port p with `phyMask[p]`=1 and p not equal to CPU_PORT gets the same three steps in ascending port order. For these ports the map is only the CPU_PORT bit. Ports with a clear mask bit get no access, and the mask bit of the CPU port is ignored.
- R10: `rspDone` with `rspErr` aborts the run: no further requests are issued and `busy` falls. `fault` is then high until the next accepted start clears it.
- R11: After reset, `busy`, `reqValid`, `fault` and `timedOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a bring-up run |
| phyMask | input | NUM_PORTS | Selects the ports to configure as PHY ports |
| busy | output | 1 | High while a run is in progress |
| fault | output | 1 | Sticky: a register access returned an error |
| timedOut | output | 1 | Sticky: the soft reset bit never cleared |
| reqValid | output | 1 | Register access request |
| reqWrite | output | 1 | 1 = write, 0 = read |
| reqDev | output | 5 | Device address of the access |
| reqReg | output | 5 | Register address of the access |
| reqWdata | output | 16 | Write data |
| rspDone | input | 1 | Access complete, one-cycle strobe |
| rspRdata | input | 16 | Read data, valid with `rspDone` |
| rspErr | input | 1 | Access failed, valid with `rspDone` |

## Verification
A wrong state in the sequencer shows up at the next request. It appears as an access to the wrong device or register, or a write whose untouched bits differ from what was read, or an access to a port outside the mask. The bench compares each request against its own ordered list in the cycle the request appears. A wrong timer or poll counter shows up as a request that comes too early after the drain or between polls, or as a poll count that differs from the list. A lost abort shows up as a further request after an error.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  localparam logic [4:0] DEV_PORT_BASE = 5'h10;
  localparam logic [4:0] DEV_GLOBAL    = 5'h1B;

  localparam logic [4:0] REG_PORT_CTRL = 5'h04;
  localparam logic [4:0] REG_VLAN_MAP  = 5'h06;
  localparam logic [4:0] REG_DEF_VID   = 5'h07;
  localparam logic [4:0] REG_GLB_CTRL  = 5'h04;
  localparam logic [4:0] REG_GLB_MON   = 5'h1A;

  localparam int         RST_BIT      = 15;
  localparam logic [15:0] RST_MASK    = 16'h8000;
  localparam logic [15:0] PSTATE_MASK = 16'h0003;
  localparam logic [15:0] PSTATE_OFF  = 16'h0000;
  localparam logic [15:0] PSTATE_FWD  = 16'h0003;
  localparam logic [15:0] DEST_MASK   = 16'h00F0;
  localparam int          DEST_LSB    = 4;
  localparam logic [15:0] VID_MASK    = 16'h0FFF;

  typedef enum logic [2:0] {
    FLD_PORT_OFF,
    FLD_SWRST,
    FLD_CPU_DEST,
    FLD_DEF_VID,
    FLD_VLAN_MAP,
    FLD_PORT_FWD
  } fieldSel_e;

  typedef struct packed {
    logic      reqOn;
    logic      reqWr;
    fieldSel_e fsel;
    logic      latchRd;
    logic      portClr;
    logic      portInc;
    logic      useCpu;
    logic      timerClr;
    logic      pollClr;
    logic      pollInc;
  } ctlStrobe_t;

  typedef struct packed {
    logic portLast;
    logic portEligible;
    logic drainDone;
    logic gapDone;
    logic pollLast;
    logic rstPending;
  } dpStatus_t;

endpackage

// File: rtl/bringup_dpath.sv
module bringup_dpath
  import bringup_pkg::*;
#(
  parameter int NUM_PORTS  = 11,
  parameter int CPU_PORT   = 5,
  parameter int CYC_PER_MS = 50000,
  parameter int DRAIN_MS   = 2,
  parameter int MAX_POLLS  = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           ctl,
  input  logic [NUM_PORTS-1:0] phyMask,
  input  logic [15:0]          rspRdata,
  output dpStatus_t            st,
  output logic                 reqValid,
  output logic                 reqWrite,
  output logic [4:0]           reqDev,
  output logic [4:0]           reqReg,
  output logic [15:0]          reqWdata
);

  localparam int PW    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int PCW   = $clog2(CYC_PER_MS + 1);
  localparam int MSW   = $clog2(DRAIN_MS + 2);
  localparam int POLLW = $clog2(MAX_POLLS + 1);
  localparam logic [15:0] ALL_PORTS = 16'((32'd1 << NUM_PORTS) - 32'd1);
  localparam logic [15:0] CPU_BIT   = 16'(32'd1 << CPU_PORT);
  localparam logic [15:0] DEST_VAL  = 16'(CPU_PORT << DEST_LSB);

  logic [PW-1:0]    portCnt;
  logic [PW-1:0]    curPort;
  logic [PCW-1:0]   preCnt;
  logic [MSW-1:0]   msCnt;
  logic [POLLW-1:0] pollCnt;
  logic [15:0]      rdLatch;
  logic [NUM_PORTS-1:0] eligVec;
  logic [4:0]       portDev;
  logic [4:0]       fDev;
  logic [4:0]       fReg;
  logic [15:0]      fMask;
  logic [15:0]      fVal;

  // Port walker
  always_ff @(posedge clk) begin
    if (!rstN)            portCnt <= '0;
    else if (ctl.portClr) portCnt <= '0;
    else if (ctl.portInc) portCnt <= portCnt + PW'(1);
  end

  assign curPort = ctl.useCpu ? PW'(CPU_PORT) : portCnt;
  assign portDev = DEV_PORT_BASE + 5'(curPort);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_elig
    assign eligVec[i] = phyMask[i] && (i != CPU_PORT);
  end

  assign st.portLast     = (portCnt == PW'(NUM_PORTS - 1));
  assign st.portEligible = eligVec[portCnt];

  // Millisecond timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (ctl.timerClr) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (preCnt == PCW'(CYC_PER_MS - 1)) begin
      preCnt <= '0;
      if (msCnt != '1) msCnt <= msCnt + MSW'(1);
    end else begin
      preCnt <= preCnt + PCW'(1);
    end
  end

  assign st.drainDone = (msCnt >= MSW'(DRAIN_MS));
  assign st.gapDone   = (msCnt != '0);

  // R4
  prescale_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(preCnt) < CYC_PER_MS);

  // Reset poll counter
  always_ff @(posedge clk) begin
    if (!rstN)            pollCnt <= '0;
    else if (ctl.pollClr) pollCnt <= '0;
    else if (ctl.pollInc) pollCnt <= pollCnt + POLLW'(1);
  end

  assign st.pollLast   = (pollCnt == POLLW'(MAX_POLLS - 1));
  assign st.rstPending = rspRdata[RST_BIT];

  // R6
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(pollCnt) < MAX_POLLS);

  // Read half of read-modify-write
  always_ff @(posedge clk) begin
    if (!rstN)            rdLatch <= '0;
    else if (ctl.latchRd) rdLatch <= rspRdata;
  end

  // Field decode
  always_comb begin
    fDev  = DEV_GLOBAL;
    fReg  = REG_GLB_CTRL;
    fMask = '0;
    fVal  = '0;
    case (ctl.fsel)
      FLD_PORT_OFF: begin
        fDev = portDev; fReg = REG_PORT_CTRL; fMask = PSTATE_MASK; fVal = PSTATE_OFF;
      end
      FLD_SWRST: begin
        fDev = DEV_GLOBAL; fReg = REG_GLB_CTRL; fMask = RST_MASK; fVal = RST_MASK;
      end
      FLD_CPU_DEST: begin
        fDev = DEV_GLOBAL; fReg = REG_GLB_MON; fMask = DEST_MASK; fVal = DEST_VAL;
      end
      FLD_DEF_VID: begin
        fDev = portDev; fReg = REG_DEF_VID; fMask = VID_MASK;
        fVal = 16'(curPort) + 16'd1;
      end
      FLD_VLAN_MAP: begin
        fDev = portDev; fReg = REG_VLAN_MAP; fMask = ALL_PORTS;
        fVal = ctl.useCpu ? (ALL_PORTS & ~CPU_BIT) : CPU_BIT;
      end
      FLD_PORT_FWD: begin
        fDev = portDev; fReg = REG_PORT_CTRL; fMask = PSTATE_MASK; fVal = PSTATE_FWD;
      end
      default: ;
    endcase
  end

  assign reqValid = ctl.reqOn;
  assign reqWrite = ctl.reqWr;
  assign reqDev   = fDev;
  assign reqReg   = fReg;
  assign reqWdata = (rdLatch & ~fMask) | (fVal & fMask);

endmodule

// File: rtl/bringup_ctrl.sv
module bringup_ctrl
  import bringup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       rspDone,
  input  logic       rspErr,
  input  dpStatus_t  st,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       fault,
  output logic       timedOut
);

  typedef enum logic [4:0] {
    S_IDLE, S_DIS_RD, S_DIS_WR, S_DRAIN, S_RST_RD, S_RST_WR,
    S_POLL_RD, S_POLL_DLY, S_DEST_RD, S_DEST_WR,
    S_VID_RD, S_VID_WR, S_MAP_RD, S_MAP_WR, S_FWD_RD, S_FWD_WR, S_SCAN
  } state_e;

  state_e state;
  state_e nextState;
  logic   cfgCpu;
  logic   accOk;
  logic   accErr;

  assign accOk = rspDone && !rspErr;

  always_comb begin
    ctl        = '0;
    ctl.fsel   = FLD_PORT_OFF;
    ctl.useCpu = cfgCpu;
    nextState  = state;
    case (state)
      S_IDLE: if (start) begin
        ctl.portClr = 1'b1;
        nextState   = S_DIS_RD;
      end
      S_DIS_RD: begin
        ctl.reqOn = 1'b1;
        if (accOk) nextState = S_DIS_WR;
      end
      S_DIS_WR: begin
        ctl.reqOn = 1'b1; ctl.reqWr = 1'b1;
        if (accOk) begin
          if (st.portLast) begin ctl.timerClr = 1'b1; nextState = S_DRAIN; end
          else begin ctl.portInc = 1'b1; nextState = S_DIS_RD; end
        end
      end
      S_DRAIN: if (st.drainDone) nextState = S_RST_RD;
      S_RST_RD: begin
        ctl.reqOn = 1'b1; ctl.fsel = FLD_SWRST;
        if (accOk) nextState = S_RST_WR;
      end
      S_RST_WR: begin
        ctl.reqOn = 1'b1; ctl.reqWr = 1'b1; ctl.fsel = FLD_SWRST;
        if (accOk) begin ctl.pollClr = 1'b1; nextState = S_POLL_RD; end
      end
      S_POLL_RD: begin
        ctl.reqOn = 1'b1; ctl.fsel = FLD_SWRST;
        if (accOk) begin
          if (!st.rstPending) nextState = S_DEST_RD;
          else if (st.pollLast) nextState = S_IDLE;
          else begin
            ctl.pollInc  = 1'b1;
            ctl.timerClr = 1'b1;
            nextState    = S_POLL_DLY;
          end
        end
      end
      S_POLL_DLY: if (st.gapDone) nextState = S_POLL_RD;
      S_DEST_RD: begin
        ctl.reqOn = 1'b1; ctl.fsel = FLD_CPU_DEST;
        if (accOk) nextState = S_DEST_WR;
      end
      S_DEST_WR: begin
        ctl.reqOn = 1'b1; ctl.reqWr = 1'b1; ctl.fsel = FLD_CPU_DEST;
        if (accOk) nextState = S_VID_RD;
      end
      S_VID_RD: begin
        ctl.reqOn = 1'b1; ctl.fsel = FLD_DEF_VID;
        if (accOk) nextState = S_VID_WR;
      end
      S_VID_WR: begin
        ctl.reqOn = 1'b1; ctl.reqWr = 1'b1; ctl.fsel = FLD_DEF_VID;
        if (accOk) nextState = S_MAP_RD;
      end
      S_MAP_RD: begin
        ctl.reqOn = 1'b1; ctl.fsel = FLD_VLAN_MAP;
        if (accOk) nextState = S_MAP_WR;
      end
      S_MAP_WR: begin
        ctl.reqOn = 1'b1; ctl.reqWr = 1'b1; ctl.fsel = FLD_VLAN_MAP;
        if (accOk) nextState = S_FWD_RD;
      end
      S_FWD_RD: begin
        ctl.reqOn = 1'b1; ctl.fsel = FLD_PORT_FWD;
        if (accOk) nextState = S_FWD_WR;
      end
      S_FWD_WR: begin
        ctl.reqOn = 1'b1; ctl.reqWr = 1'b1; ctl.fsel = FLD_PORT_FWD;
        if (accOk) begin
          if (cfgCpu) begin ctl.portClr = 1'b1; nextState = S_SCAN; end
          else if (st.portLast) nextState = S_IDLE;
          else begin ctl.portInc = 1'b1; nextState = S_SCAN; end
        end
      end
      S_SCAN: begin
        if (st.portEligible) nextState = S_VID_RD;
        else if (st.portLast) nextState = S_IDLE;
        else ctl.portInc = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
    ctl.latchRd = ctl.reqOn && !ctl.reqWr && rspDone;
    if (ctl.reqOn && rspDone && rspErr) nextState = S_IDLE;
  end

  assign accErr = ctl.reqOn && rspDone && rspErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cfgCpu   <= 1'b0;
      fault    <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) begin
        fault    <= 1'b0;
        timedOut <= 1'b0;
      end
      if (accErr) fault <= 1'b1;
      if (state == S_POLL_RD && accOk && st.rstPending && st.pollLast) timedOut <= 1'b1;
      if (accErr) cfgCpu <= 1'b0;
      else if (state == S_DEST_WR && accOk) cfgCpu <= 1'b1;
      else if (state == S_FWD_WR && accOk) cfgCpu <= 1'b0;
    end
  end

  assign busy = (state != S_IDLE);

  // R10
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !busy);

  // R10
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fault) |-> $past(rspDone && rspErr));

  // R6
  timeout_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |-> !busy);

endmodule

// File: rtl/switch_bringup_seq.sv
module switch_bringup_seq
  import bringup_pkg::*;
#(
  parameter int NUM_PORTS  = 11,
  parameter int CPU_PORT   = 5,
  parameter int CYC_PER_MS = 50000,
  parameter int DRAIN_MS   = 2,
  parameter int MAX_POLLS  = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [NUM_PORTS-1:0] phyMask,
  output logic                 busy,
  output logic                 fault,
  output logic                 timedOut,
  output logic                 reqValid,
  output logic                 reqWrite,
  output logic [4:0]           reqDev,
  output logic [4:0]           reqReg,
  output logic [15:0]          reqWdata,
  input  logic                 rspDone,
  input  logic [15:0]          rspRdata,
  input  logic                 rspErr
);

  ctlStrobe_t ctl;
  dpStatus_t  st;

  bringup_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rspDone  (rspDone),
    .rspErr   (rspErr),
    .st       (st),
    .ctl      (ctl),
    .busy     (busy),
    .fault    (fault),
    .timedOut (timedOut)
  );

  bringup_dpath #(
    .NUM_PORTS  (NUM_PORTS),
    .CPU_PORT   (CPU_PORT),
    .CYC_PER_MS (CYC_PER_MS),
    .DRAIN_MS   (DRAIN_MS),
    .MAX_POLLS  (MAX_POLLS)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .phyMask  (phyMask),
    .rspRdata (rspRdata),
    .st       (st),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqDev   (reqDev),
    .reqReg   (reqReg),
    .reqWdata (reqWdata)
  );

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !rspDone) |=> (reqValid && $stable(reqWrite) && $stable(reqDev)
                                && $stable(reqReg) && $stable(reqWdata)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid);

endmodule

// File: tb/switch_bringup_seq_test.sv
`timescale 1ns/1ps
module switch_bringup_seq_test;

  localparam int NPORTS = 11;
  localparam int CPU    = 5;
  localparam int CYC    = 20;
  localparam int DRAINM = 2;
  localparam int MAXP   = 6;
  localparam logic [15:0] ALLP   = 16'h07FF;
  localparam logic [15:0] CPUBIT = 16'h0020;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NPORTS-1:0] phyMask = '0;
  logic busy, fault, timedOut, reqValid, reqWrite;
  logic [4:0] reqDev, reqReg;
  logic [15:0] reqWdata;
  logic rspDone = 1'b0;
  logic [15:0] rspRdata = '0;
  logic rspErr = 1'b0;

  always #10 clk = ~clk;

  switch_bringup_seq #(
    .NUM_PORTS(NPORTS), .CPU_PORT(CPU), .CYC_PER_MS(CYC),
    .DRAIN_MS(DRAINM), .MAX_POLLS(MAXP)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .phyMask(phyMask),
    .busy(busy), .fault(fault), .timedOut(timedOut),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqDev(reqDev),
    .reqReg(reqReg), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  dev;
    logic [4:0]  rg;
    logic [15:0] data;
    logic [31:0] minGap;
    logic [7:0]  req;
  } item_t;

  item_t expQ[$];
  logic [15:0] regs [1024];
  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  int accIdx = 0;
  int errAtG = -1;
  int kG = 0;
  int pollsLeft = 0;
  int lastDoneCyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input int req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] initVal(input logic [4:0] d, input logic [4:0] r);
    return ((16'(d) * 16'h0913) ^ (16'(r) * 16'h2C61) ^ 16'h5A3C) & 16'h7FFF;
  endfunction

  function automatic logic [4:0] pdev(input int p);
    return 5'(16 + p);
  endfunction

  task automatic push(input logic wr, input logic [4:0] dev, input logic [4:0] rg,
                      input logic [15:0] data, input int gap, input int req);
    item_t e;
    e.wr = wr; e.dev = dev; e.rg = rg; e.data = data;
    e.minGap = 32'(gap); e.req = 8'(req);
    expQ.push_back(e);
  endtask

  // R8 / R9: VID, map, forwarding state for one port
  task automatic cfgPort(input int p, input logic [15:0] map, input int req);
    push(0, pdev(p), 5'h07, 16'h0, 0, req);
    push(1, pdev(p), 5'h07, (initVal(pdev(p), 5'h07) & ~16'h0FFF) | 16'(p + 1), 0, req);
    push(0, pdev(p), 5'h06, 16'h0, 0, req);
    push(1, pdev(p), 5'h06, (initVal(pdev(p), 5'h06) & ~ALLP) | map, 0, req);
    push(0, pdev(p), 5'h04, 16'h0, 0, req);
    push(1, pdev(p), 5'h04, initVal(pdev(p), 5'h04) | 16'h0003, 0, req);
  endtask

  task automatic buildSeq(input logic [NPORTS-1:0] mask, input int k, input int errAt);
    int n;
    expQ.delete();
    // R3: disable every port, state bits 1:0 -> 0
    for (int p = 0; p < NPORTS; p++) begin
      push(0, pdev(p), 5'h04, 16'h0, 0, 3);
      push(1, pdev(p), 5'h04, initVal(pdev(p), 5'h04) & 16'hFFFC, 0, 3);
    end
    // R4: drain gap before the reset read; R5: set bit 15
    push(0, 5'h1B, 5'h04, 16'h0, DRAINM * CYC, 4);
    push(1, 5'h1B, 5'h04, initVal(5'h1B, 5'h04) | 16'h8000, 0, 5);
    // R6: polls
    n = (k + 1 <= MAXP) ? k + 1 : MAXP;
    for (int i = 0; i < n; i++) push(0, 5'h1B, 5'h04, 16'h0, (i == 0) ? 0 : CYC, 6);
    if (k + 1 <= MAXP) begin
      // R7: CPU destination bits 7:4
      push(0, 5'h1B, 5'h1A, 16'h0, 0, 7);
      push(1, 5'h1B, 5'h1A, (initVal(5'h1B, 5'h1A) & 16'hFF0F) | 16'(CPU << 4), 0, 7);
      cfgPort(CPU, ALLP & ~CPUBIT, 8);
      for (int p = 0; p < NPORTS; p++)
        if (mask[p] && p != CPU) cfgPort(p, CPUBIT, 9);
    end
    if (errAt >= 0) while (expQ.size() > errAt + 1) void'(expQ.pop_back());
  endtask

  // Responder and monitor: serves accesses and pops the scoreboard
  logic        cWr;
  logic [4:0]  cDev, cReg;
  logic [15:0] cDat, rv;
  int          startCyc;
  bit          stableOk;
  item_t       e;

  initial begin : responder
    forever begin
      @(negedge clk);
      if (rstN && reqValid) begin
        cWr = reqWrite; cDev = reqDev; cReg = reqReg; cDat = reqWdata;
        startCyc = cyc; stableOk = 1;
        repeat (1 + accIdx % 3) begin
          @(negedge clk);
          if (reqValid !== 1'b1 || reqWrite !== cWr || reqDev !== cDev ||
              reqReg !== cReg || reqWdata !== cDat) stableOk = 0;
        end
        // R2: request held until done
        chk(stableOk, 2, "request held until done", 32'(stableOk), 32'd1);
        if (expQ.size() == 0) begin
          // R1 / R10: no request expected here
          chk(0, 1, "unexpected request", {5'd0, cWr, cDev, cReg, cDat}, 32'd0);
        end else begin
          e = expQ.pop_front();
          chk((cWr == e.wr) && (cDev == e.dev) && (cReg == e.rg) && (!e.wr || cDat == e.data),
              int'(e.req), "access", {5'd0, cWr, cDev, cReg, cDat},
              {5'd0, e.wr, e.dev, e.rg, e.wr ? e.data : cDat});
          if (e.minGap != 0)
            chk((startCyc - lastDoneCyc) >= int'(e.minGap), int'(e.req), "idle gap",
                32'(startCyc - lastDoneCyc), e.minGap);
        end
        rv = regs[{cDev, cReg}];
        if (cWr) begin
          regs[{cDev, cReg}] = cDat;
          if (cDev == 5'h1B && cReg == 5'h04) pollsLeft = kG;
        end else if (cDev == 5'h1B && cReg == 5'h04) begin
          if (pollsLeft > 0) begin rv = rv | 16'h8000; pollsLeft--; end
          else rv = rv & 16'h7FFF;
        end
        rspRdata = rv;
        rspErr = (accIdx == errAtG);
        rspDone = 1'b1;
        @(negedge clk);
        rspDone = 1'b0;
        rspErr = 1'b0;
        lastDoneCyc = cyc;
        accIdx++;
      end
    end
  end

  task automatic runTest(input logic [NPORTS-1:0] mask, input int k, input int errAt,
                         input bit expFault, input bit expTmo, input bit restartMid);
    int t;
    for (int i = 0; i < 1024; i++) regs[i] = initVal(5'(i >> 5), 5'(i));
    buildSeq(mask, k, errAt);
    accIdx = 0; errAtG = errAt; kG = k; pollsLeft = 0;
    @(negedge clk);
    phyMask = mask;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: busy the cycle after start
    chk(busy == 1'b1, 1, "busy after start", 32'(busy), 32'd1);
    // R10: sticky flags cleared by an accepted start
    chk(fault == 1'b0 && timedOut == 1'b0, 10, "flags cleared on start",
        {fault, timedOut}, 32'd0);
    if (restartMid) begin
      repeat (30) @(negedge clk);
      start = 1'b1;   // R1: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    chk(!busy, 1, "run finished", 32'(busy), 32'd0);
    repeat (12) @(negedge clk);
    chk(expQ.size() == 0, 3, "all expected accesses seen", 32'(expQ.size()), 32'd0);
    chk(!reqValid, 10, "no request after end", 32'(reqValid), 32'd0);
    chk(fault == expFault, 10, "fault flag", 32'(fault), 32'(expFault));
    chk(timedOut == expTmo, 6, "timeout flag", 32'(timedOut), 32'(expTmo));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R1 watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin : driver
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(!busy && !reqValid && !fault && !timedOut, 11, "reset state",
        {busy, reqValid, fault, timedOut}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !reqValid, 11, "idle after reset", {busy, reqValid}, 32'd0);
    // R3 R4 R5 R6 R7 R8 R9: sparse mask, two busy polls, restart ignored (R1)
    runTest(11'b000_1000_1011, 2, -1, 1'b0, 1'b0, 1'b1);
    // R9: full mask incl. CPU bit (ignored), reset clears at first poll
    runTest(11'b111_1111_1111, 0, -1, 1'b0, 1'b0, 1'b0);
    // R6: reset bit never clears -> MAX polls then timeout
    runTest(11'b000_0000_0001, 100, -1, 1'b0, 1'b1, 1'b0);
    // R10: error on sixth access aborts
    runTest(11'b000_0000_0011, 1, 5, 1'b1, 1'b0, 1'b0);
    // R10: next start clears fault; empty mask configures only the CPU port
    runTest(11'b000_0000_0000, 1, -1, 1'b0, 1'b0, 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule